// File: doc/BRIEF.md
# Interrupt Take and Delegation Arbiter

This block sits beside the trap logic of a hart and decides, once per clock, whether an interrupt has to be taken. It also decides which cause number is reported and whether the handler runs in machine mode or supervisor mode. It combines four things to reach that decision:

- the pending and enable vectors;
- a per-cause delegation mask;
- the current privilege level;
- the machine-level and supervisor-level global enables.

A separate non-maskable request input overrides all of them.

The decision is registered. The take strobe, cause, target flag and exception-suppress flag therefore appear one cycle after the inputs are presented. The pipeline drives a trap-acknowledge input high when it is able to accept a trap; while that input is low, no take is issued. When a take coincides with a synchronous exception, the block raises an exception-suppress output, so the pipeline lets the interrupt win.

Top module: `irq_arbiter`

## Requirements
- R1: A cause is a candidate only when its pending bit, its enable bit and its global enable are all 1. The outputs for a given input set appear after the next rising clock edge, and are all 0 when nothing is taken.
- R2: A cause whose effective delegation bit is 0 targets machine mode (`tgt_m_o`=1). Its global enable is 1 when `priv_i` is not machine (2'b11), or when `priv_i` is machine and `m_gie_i`=1. The privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R3: A cause whose effective delegation bit is 1 targets supervisor mode (`tgt_m_o`=0). Its global enable is 1 when `priv_i` is user, or when `priv_i` is supervisor and `s_gie_i`=1. It is never taken while `priv_i` is machine.
- R4: Only causes 1, 5 and 9 and causes 16 and above can be delegated. The delegation bits of causes 3, 7 and 11 are ignored. Causes 0, 2, 4, 6, 8, 10 and 12 to 15 are never taken.
- R5: When candidates exist for both targets, a machine-target candidate wins over every supervisor-target candidate.
- R6: Within one target, the standard causes rank in this order from first to last: 11, 3, 7, 9, 1, 5.
- R7: Causes 16 and above rank below all standard causes, and among themselves the lowest index wins.
- R8: When `nmi_i`=1, the take is issued with `nmi_o`=1, `tgt_m_o`=1 and `cause_o`=NMI_CAUSE, whatever the pending, enable, delegation and privilege inputs are.
- R9: While `ack_i`=0, the following cycle shows `take_o`=0 even if a candidate or a non-maskable request is present.
- R10: `exc_kill_o` is 1 exactly when a take is issued and `exc_i` was 1 in the same input cycle.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NIRQ | Pending vector, bit i is cause i |
| en_i | input | NIRQ | Per-cause enable vector |
| deleg_i | input | NIRQ | Requested delegation to supervisor mode |
| priv_i | input | 2 | Current privilege (U=00, S=01, M=11) |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| nmi_i | input | 1 | Non-maskable interrupt request |
| ack_i | input | 1 | Pipeline can accept a trap |
| exc_i | input | 1 | A synchronous exception is pending |
| take_o | output | 1 | Take an interrupt this cycle |
| nmi_o | output | 1 | The take is the non-maskable interrupt |
| tgt_m_o | output | 1 | Handler runs in machine mode (0: supervisor) |
| cause_o | output | $clog2(NIRQ) | Cause number of the take |
| exc_kill_o | output | 1 | Suppress the simultaneous synchronous exception |

## Verification
The bench builds the block with NIRQ=32 and NMI_CAUSE=0. At that width the custom causes 16 through 31 are in reach, including the top index. This makes it possible to check three things:

- custom causes rank below the standard ones;
- among custom causes, the lowest index wins;
- an undelegated custom cause beats a delegated standard cause.

With a 5-bit cause field, any slip in the priority walk or the delegation mask shows up directly on `cause_o`.

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int NIRQ = 32,
  parameter int NMI_CAUSE = 0,
  localparam int CW = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  input  logic [NIRQ-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  input  logic            nmi_i,
  input  logic            ack_i,
  input  logic            exc_i,
  output logic            take_o,
  output logic            nmi_o,
  output logic            tgt_m_o,
  output logic [CW-1:0]   cause_o,
  output logic            exc_kill_o
);

  function automatic logic [NIRQ-1:0] mk_mask(input bit only_deleg);
    logic [NIRQ-1:0] m;
    m = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (i >= 16 || i == 1 || i == 5 || i == 9) m[i] = 1'b1;
      else if (!only_deleg && (i == 3 || i == 7 || i == 11)) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [NIRQ-1:0] IMPL  = mk_mask(1'b0);
  localparam logic [NIRQ-1:0] DELEG = mk_mask(1'b1);

  function automatic logic [CW:0] pick(input logic [NIRQ-1:0] v);
    logic [CW:0] r;
    int ord [6];
    ord = '{11, 3, 7, 9, 1, 5};
    r = '0;
    for (int i = NIRQ - 1; i >= 16; i--)
      if (v[i]) r = {1'b1, CW'(i)};
    for (int k = 5; k >= 0; k--)
      if (v[ord[k]]) r = {1'b1, CW'(ord[k])};
    return r;
  endfunction

  logic [NIRQ-1:0] deleg_eff, gen, cand, mc, sc;
  logic [CW:0]     pm, ps;
  logic            cur_m, cur_s, m_ok, s_ok, any;

  assign cur_m     = (priv_i == 2'b11);
  assign cur_s     = (priv_i == 2'b01);
  assign m_ok      = !cur_m || m_gie_i;
  assign s_ok      = (!cur_m && !cur_s) || (cur_s && s_gie_i);
  assign deleg_eff = deleg_i & DELEG;
  assign gen       = ({NIRQ{m_ok}} & ~deleg_eff) | ({NIRQ{s_ok}} & deleg_eff);
  assign cand      = pend_i & en_i & IMPL & gen;
  assign mc        = cand & ~deleg_eff;
  assign sc        = cand & deleg_eff;
  assign pm        = pick(mc);
  assign ps        = pick(sc);
  assign any       = nmi_i || pm[CW] || ps[CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      nmi_o      <= 1'b0;
      tgt_m_o    <= 1'b0;
      cause_o    <= '0;
      exc_kill_o <= 1'b0;
    end else begin
      take_o     <= ack_i && any;
      nmi_o      <= ack_i && nmi_i;
      tgt_m_o    <= ack_i && (nmi_i || pm[CW]);
      exc_kill_o <= ack_i && any && exc_i;
      if (!ack_i)       cause_o <= '0;
      else if (nmi_i)   cause_o <= CW'(NMI_CAUSE);
      else if (pm[CW])  cause_o <= pm[CW-1:0];
      else if (ps[CW])  cause_o <= ps[CW-1:0];
      else              cause_o <= '0;
    end
  end

  p_cause_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && !nmi_o |-> |(($past(pend_i & en_i) >> cause_o) & NIRQ'(1)));
  p_s_not_in_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && !nmi_o && !tgt_m_o |-> $past(priv_i) != 2'b11);
  p_nmi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i && ack_i |=> take_o && nmi_o && tgt_m_o);
  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !take_o);
  p_kill_with_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_kill_o |-> take_o);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> !nmi_o && !tgt_m_o && cause_o == '0);

endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  localparam int N = 32;
  localparam int CW = $clog2(N);
  localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pend = '0, en = '0, deleg = '0;
  logic [1:0] priv = PM;
  logic mgie = 0, sgie = 0, nmi = 0, ack = 1, exc = 0;
  logic take, nmi_o, tgt_m, kill;
  logic [CW-1:0] cause;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct {
    int due; logic t, n, m, k; logic [CW-1:0] c; string req;
  } exp_t;
  exp_t q[$];

  irq_arbiter #(.NIRQ(N), .NMI_CAUSE(0)) dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie), .nmi_i(nmi), .ack_i(ack),
    .exc_i(exc), .take_o(take), .nmi_o(nmi_o), .tgt_m_o(tgt_m),
    .cause_o(cause), .exc_kill_o(kill));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [N-1:0] b(input int i);
    return N'(1) << i;
  endfunction

  task automatic drive(input logic [N-1:0] p, e, d, input logic [1:0] pv,
                       input logic mg, sg, nm, ak, ex,
                       input logic et, en_, em, ek, input int ec, input string req);
    exp_t x;
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pv; mgie = mg; sgie = sg;
    nmi = nm; ack = ak; exc = ex;
    x.due = cyc + 1; x.t = et; x.n = en_; x.m = em; x.k = ek; x.c = CW'(ec); x.req = req;
    q.push_back(x);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (take !== x.t || nmi_o !== x.n || tgt_m !== x.m || kill !== x.k || cause !== x.c) begin
        fails++;
        $display("FAIL %s: got take=%0b nmi=%0b tgt_m=%0b kill=%0b cause=%0d, expected take=%0b nmi=%0b tgt_m=%0b kill=%0b cause=%0d",
                 x.req, take, nmi_o, tgt_m, kill, cause, x.t, x.n, x.m, x.k, x.c);
      end
    end
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pend = b(11); en = b(11); mgie = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (take !== 0 || nmi_o !== 0 || tgt_m !== 0 || cause !== 0 || kill !== 0) begin
      fails++;
      $display("FAIL R11: got take=%0b cause=%0d, expected all zero", take, cause);
    end
    rst_n = 1;
    // R1
    drive(b(11), b(11), 0, PM, 1, 0, 0, 1, 0, 1, 0, 1, 0, 11, "R1 taken");
    drive(b(11), 0, 0, PM, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R1 disabled");
    // R2
    drive(b(7), b(7), 0, PM, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 M mie=0");
    drive(b(7), b(7), 0, PS, 0, 0, 0, 1, 0, 1, 0, 1, 0, 7, "R2 below M");
    // R3
    drive(b(5), b(5), b(5), PS, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 S sie=0");
    drive(b(5), b(5), b(5), PS, 0, 1, 0, 1, 0, 1, 0, 0, 0, 5, "R3 S sie=1");
    drive(b(5), b(5), b(5), PU, 0, 0, 0, 1, 0, 1, 0, 0, 0, 5, "R3 from U");
    drive(b(5), b(5), b(5), PM, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R3 never in M");
    // R4
    drive(b(3), b(3), b(3), PS, 0, 0, 0, 1, 0, 1, 0, 1, 0, 3, "R4 cause 3 stays M");
    drive(b(2) | b(13), b(2) | b(13), 0, PU, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R4 reserved");
    // R5
    drive(b(1) | b(16), b(1) | b(16), b(1), PU, 0, 0, 0, 1, 0, 1, 0, 1, 0, 16, "R5 M target wins");
    // R6
    drive(b(11) | b(3) | b(7), b(11) | b(3) | b(7), 0, PU, 0, 0, 0, 1, 0, 1, 0, 1, 0, 11, "R6 11 first");
    drive(b(3) | b(7) | b(9), b(3) | b(7) | b(9), 0, PU, 0, 0, 0, 1, 0, 1, 0, 1, 0, 3, "R6 3 before 7");
    drive(b(7) | b(9) | b(1) | b(5), '1, 0, PU, 0, 0, 0, 1, 0, 1, 0, 1, 0, 7, "R6 7 before 9");
    drive(b(9) | b(1) | b(5), '1, b(9) | b(1) | b(5), PU, 0, 0, 0, 1, 0, 1, 0, 0, 0, 9, "R6 9 first in S");
    drive(b(1) | b(5), '1, b(1) | b(5), PU, 0, 0, 0, 1, 0, 1, 0, 0, 0, 1, "R6 1 before 5");
    // R7
    drive(b(16) | b(20) | b(5), '1, 0, PU, 0, 0, 0, 1, 0, 1, 0, 1, 0, 5, "R7 standard first");
    drive(b(20) | b(16), '1, 0, PU, 0, 0, 0, 1, 0, 1, 0, 1, 0, 16, "R7 lowest custom");
    drive(b(31), '1, b(31), PU, 0, 0, 0, 1, 0, 1, 0, 0, 0, 31, "R7 top custom delegated");
    // R8
    drive(0, 0, 0, PM, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0, "R8 nmi alone");
    drive(b(9), b(9), b(9), PU, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0, "R8 nmi over S");
    // R9
    drive(b(11), b(11), 0, PU, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 no ack");
    drive(0, 0, 0, PU, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, "R9 no ack nmi");
    // R10
    drive(b(7), b(7), 0, PU, 0, 0, 0, 1, 1, 1, 0, 1, 1, 7, "R10 kill");
    drive(0, 0, 0, PU, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R10 no kill");
    drive(0, 0, 0, PU, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R1 idle");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending, expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule